// File: doc/BRIEF.md
# Unlock command sequence decoder

This block watches the write cycles of an asynchronous parallel flash bus and turns the multi-cycle unlock sequences written there into single-cycle command strobes in the system clock domain. The chip-enable, write-enable and output-enable strobes are brought into the clock domain through two-stage synchronisers. A write cycle starts when chip enable and write enable are both low while output enable is high. The address is captured when that condition begins, and the data is taken when it ends. Only after two fixed key writes, followed by a command write, does the block issue a command. Any stray write returns it to read mode.

The strobes drive an array controller and an erase engine. Neither is part of this block. The block issues strobes for read-mode reset, identification entry, program (with the captured address and data), whole-array erase, sector erase (with a sector index from a non-uniform sector map), and erase hold and continue. While identification mode is active it also returns the identification word for the current read address. The key addresses move by half a word in byte mode. The decoder ignores writes while the supply is low or while a program operation is running.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset the block is in read mode: `ident_mode` is 0, `ident_data` is 0 and no command strobe is high.
- R2: A write cycle is counted only when `bus_ce_n` and `bus_we_n` are both low and `bus_oe_n` is high. A strobe pattern with `bus_oe_n` low is not a write and does not advance a sequence.
- R3: In word mode the sequence is key A (word address 555h, data AAh), then key B (word address 2AAh, data 55h), then a command write at 555h. Only address bits 10..0 are compared, `bus_addr_lsb` is ignored, and commands use data bits 7..0.
- R4: In byte mode the byte address is {`bus_addr`, `bus_addr_lsb`}. Key A is at byte AAAh (word 555h, lsb 0), key B is at byte 555h (word 2AAh, lsb 1), and the command is at byte AAAh. A key B write with lsb 0 aborts the sequence.
- R5: Command 90h pulses `cmd_ident` and enters identification mode. In that mode, with address bit 6 low, word offset 0 reads the maker code 0001h and offset 1 reads the device code. Offset 2 reads 1 if the addressed sector's bit in `sect_prot` is set and 0 if it is not. Every other address reads 0. In byte mode bits 15..8 read 0, and outside identification mode `ident_data` is 0.
- R6: Command A0h arms program. The next write pulses `cmd_prog` with `prog_addr`, `prog_lsb` and `prog_data` set to that write's address, lsb and full data word. This holds even when the data is F0h.
- R7: Command 80h needs a second key A/key B pair. A final write of 10h at the command address pulses `cmd_chip_erase`. A final write of 30h at any address pulses `cmd_sect_erase`.
- R8: A wrong address, wrong data or wrong order at any step returns the block to read mode with no strobe. A stray write also ends identification mode.
- R9: Data F0h at any address, in any state other than an armed program, pulses `cmd_reset` and returns to read mode.
- R10: While `serase_busy` is high, a single write of B0h at any address pulses `cmd_suspend`, and a single write of 30h from read mode pulses `cmd_resume`. When `serase_busy` is low, neither write has any effect.
- R11: Every write is ignored while `vdd_low` or `pgm_busy` is high, and the sequence state does not advance.
- R12: Each strobe is high for exactly one clock and at most one strobe is high at a time. A strobe rises on the third rising clock edge after the edge of `bus_we_n` or `bus_ce_n` that ends the write.
- R13: The sector index comes from word address bits 18..12 with the boot sectors at the top. Index n is used for address bits 18..15 = n when n < 15. Then 15 is the 16K-word part, 16 and 17 are the two 4K-word parts, and 18 is the top 8K-word part.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_ce_n | input | 1 | Chip enable, active low, asynchronous |
| bus_we_n | input | 1 | Write enable, active low, asynchronous |
| bus_oe_n | input | 1 | Output enable, active low, asynchronous |
| bus_addr | input | WA_W | Word address |
| bus_addr_lsb | input | 1 | Half-word address bit, used in byte mode |
| bus_dq | input | DQ_W | Write data |
| byte_mode | input | 1 | 1 = byte-wide bus, 0 = word-wide |
| vdd_low | input | 1 | Low-supply lockout |
| pgm_busy | input | 1 | Program operation in progress |
| serase_busy | input | 1 | Sector erase in progress |
| sect_prot | input | 19 | Per-sector protection flags |
| ident_mode | output | 1 | Identification mode active |
| ident_data | output | DQ_W | Identification read word |
| cmd_reset | output | 1 | Return-to-read strobe |
| cmd_ident | output | 1 | Identification entry strobe |
| cmd_prog | output | 1 | Program strobe |
| prog_addr | output | WA_W | Program word address |
| prog_lsb | output | 1 | Program half-word bit |
| prog_data | output | DQ_W | Program data |
| cmd_chip_erase | output | 1 | Whole-array erase strobe |
| cmd_sect_erase | output | 1 | Sector erase strobe |
| erase_sector | output | 5 | Sector index for sector erase |
| cmd_suspend | output | 1 | Erase hold strobe |
| cmd_resume | output | 1 | Erase continue strobe |

## Verification
A command strobe comes three clock edges after the strobe edge that ends its write cycle. The bench records the cycle counter at that bus edge and also on every falling clock edge where a strobe is high. It then checks the distance, the count and the kind of each event. The identification word is registered one edge after the address changes, so the bench holds the address for two falling edges before it compares. Captured fields are compared in the cycle where their strobe is seen.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

    localparam int NUM_SECT = 19;
    localparam int SECT_W   = 5;
    localparam int OP_W     = 8;
    localparam int KEY_W    = 11;
    localparam int HI_W     = 7;

    localparam logic [KEY_W-1:0] KEY_A_WADDR = 11'h555;
    localparam logic [KEY_W-1:0] KEY_B_WADDR = 11'h2AA;

    localparam logic [OP_W-1:0] OP_KEY_A   = 8'hAA;
    localparam logic [OP_W-1:0] OP_KEY_B   = 8'h55;
    localparam logic [OP_W-1:0] OP_RESET   = 8'hF0;
    localparam logic [OP_W-1:0] OP_IDENT   = 8'h90;
    localparam logic [OP_W-1:0] OP_PROGRAM = 8'hA0;
    localparam logic [OP_W-1:0] OP_ERS_ARM = 8'h80;
    localparam logic [OP_W-1:0] OP_CHIP    = 8'h10;
    localparam logic [OP_W-1:0] OP_SECTOR  = 8'h30;
    localparam logic [OP_W-1:0] OP_HOLD    = 8'hB0;
    localparam logic [OP_W-1:0] OP_CONT    = 8'h30;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_KEY1,
        ST_KEY2,
        ST_PGM_ARM,
        ST_ERS_ARM,
        ST_ERS_KEY1,
        ST_ERS_KEY2,
        ST_IDENT
    } seq_state_e;

    typedef struct packed {
        logic rst_rd;
        logic ident;
        logic prog;
        logic chip_ers;
        logic sect_ers;
        logic hold;
        logic cont;
    } cmd_pulse_t;

    // Word-address compare; in byte mode the half-word bit must match too.
    function automatic logic addr_is(input logic [KEY_W-1:0] w,
                                     input logic             lsb,
                                     input logic             byte_mode,
                                     input logic [KEY_W-1:0] tgt_w,
                                     input logic             tgt_lsb);
        return (w == tgt_w) && (!byte_mode || (lsb == tgt_lsb));
    endfunction

    // Sector index from word-address bits 18..12.
    function automatic logic [SECT_W-1:0] sector_of(input logic [HI_W-1:0] hi,
                                                    input logic            top_boot);
        logic [SECT_W-1:0] s;
        if (top_boot) begin
            if (hi[6:3] != 4'hF)  s = SECT_W'(hi[6:3]);
            else if (!hi[2])      s = SECT_W'(15);
            else if (hi[1])       s = SECT_W'(18);
            else if (!hi[0])      s = SECT_W'(16);
            else                  s = SECT_W'(17);
        end else begin
            if (hi[6:3] != 4'h0)  s = SECT_W'(hi[6:3]) + SECT_W'(3);
            else if (hi[2])       s = SECT_W'(3);
            else if (!hi[1])      s = SECT_W'(0);
            else if (!hi[0])      s = SECT_W'(1);
            else                  s = SECT_W'(2);
        end
        return s;
    endfunction

endpackage

// File: rtl/fcd_bus_front.sv
module fcd_bus_front #(
    parameter int WA_W = 19
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ce_n,
    input  logic            we_n,
    input  logic            oe_n,
    input  logic [WA_W-1:0] addr,
    input  logic            addr_lsb,
    output logic            wr_end,
    output logic [WA_W-1:0] lat_addr,
    output logic            lat_lsb
);
    localparam int NSTRB = 3;
    localparam int SYNC_D = 2;

    logic [NSTRB-1:0] raw;
    logic [NSTRB-1:0] synced;

    assign raw = {oe_n, we_n, ce_n};

    generate
        for (genvar i = 0; i < NSTRB; i++) begin : g_sync
            logic [SYNC_D-1:0] chain;
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= {chain[SYNC_D-2:0], raw[i]};
            end
            assign synced[i] = chain[SYNC_D-1];
        end
    endgenerate

    logic cyc_on, cyc_on_q, wr_begin;

    assign cyc_on   = !synced[0] && !synced[1] && synced[2];
    assign wr_begin = cyc_on && !cyc_on_q;
    assign wr_end   = !cyc_on && cyc_on_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc_on_q <= 1'b0;
            lat_addr <= '0;
            lat_lsb  <= 1'b0;
        end else begin
            cyc_on_q <= cyc_on;
            if (wr_begin) begin
                lat_addr <= addr;
                lat_lsb  <= addr_lsb;
            end
        end
    end

endmodule

// File: rtl/fcd_seq_ctrl.sv
module fcd_seq_ctrl
    import fcd_pkg::*;
#(
    parameter int WA_W     = 19,
    parameter int DQ_W     = 16,
    parameter bit TOP_BOOT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_end,
    input  logic [WA_W-1:0]   lat_addr,
    input  logic              lat_lsb,
    input  logic [DQ_W-1:0]   dq,
    input  logic              byte_mode,
    input  logic              vdd_low,
    input  logic              pgm_busy,
    input  logic              serase_busy,
    output logic              ident_mode,
    output cmd_pulse_t        pulse,
    output logic [WA_W-1:0]   prog_addr,
    output logic              prog_lsb,
    output logic [DQ_W-1:0]   prog_data,
    output logic [SECT_W-1:0] erase_sector
);
    seq_state_e st, st_n;
    cmd_pulse_t pulse_n;

    logic [OP_W-1:0]  op;
    logic [KEY_W-1:0] key_w;
    logic             at_a, at_b, key_a_ok, key_b_ok, take;

    assign op       = dq[OP_W-1:0];
    assign key_w    = lat_addr[KEY_W-1:0];
    assign at_a     = addr_is(key_w, lat_lsb, byte_mode, KEY_A_WADDR, 1'b0);
    assign at_b     = addr_is(key_w, lat_lsb, byte_mode, KEY_B_WADDR, 1'b1);
    assign key_a_ok = at_a && (op == OP_KEY_A);
    assign key_b_ok = at_b && (op == OP_KEY_B);
    assign take     = wr_end && !vdd_low && !pgm_busy;

    always_comb begin
        st_n    = st;
        pulse_n = '0;
        if (take) begin
            if (st == ST_PGM_ARM) begin
                pulse_n.prog = 1'b1;
                st_n         = ST_IDLE;
            end else if (op == OP_RESET) begin
                pulse_n.rst_rd = 1'b1;
                st_n           = ST_IDLE;
            end else if (serase_busy && (op == OP_HOLD)) begin
                pulse_n.hold = 1'b1;
                st_n         = ST_IDLE;
            end else if (serase_busy && (op == OP_CONT) && (st == ST_IDLE)) begin
                pulse_n.cont = 1'b1;
            end else begin
                unique case (st)
                    ST_IDLE, ST_IDENT: st_n = key_a_ok ? ST_KEY1 : ST_IDLE;
                    ST_KEY1:           st_n = key_b_ok ? ST_KEY2 : ST_IDLE;
                    ST_KEY2: begin
                        st_n = ST_IDLE;
                        if (at_a && (op == OP_IDENT)) begin
                            st_n          = ST_IDENT;
                            pulse_n.ident = 1'b1;
                        end else if (at_a && (op == OP_PROGRAM)) begin
                            st_n = ST_PGM_ARM;
                        end else if (at_a && (op == OP_ERS_ARM)) begin
                            st_n = ST_ERS_ARM;
                        end
                    end
                    ST_ERS_ARM:  st_n = key_a_ok ? ST_ERS_KEY1 : ST_IDLE;
                    ST_ERS_KEY1: st_n = key_b_ok ? ST_ERS_KEY2 : ST_IDLE;
                    ST_ERS_KEY2: begin
                        st_n = ST_IDLE;
                        if (at_a && (op == OP_CHIP))  pulse_n.chip_ers = 1'b1;
                        else if (op == OP_SECTOR)     pulse_n.sect_ers = 1'b1;
                    end
                    default: st_n = ST_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st           <= ST_IDLE;
            pulse        <= '0;
            prog_addr    <= '0;
            prog_lsb     <= 1'b0;
            prog_data    <= '0;
            erase_sector <= '0;
        end else begin
            st    <= st_n;
            pulse <= pulse_n;
            if (pulse_n.prog) begin
                prog_addr <= lat_addr;
                prog_lsb  <= lat_lsb;
                prog_data <= dq;
            end
            if (pulse_n.sect_ers)
                erase_sector <= sector_of(lat_addr[WA_W-1 -: HI_W], TOP_BOOT);
        end
    end

    assign ident_mode = (st == ST_IDENT);

endmodule

// File: rtl/fcd_ident_rom.sv
module fcd_ident_rom
    import fcd_pkg::*;
#(
    parameter int              DQ_W     = 16,
    parameter bit              TOP_BOOT = 1'b1,
    parameter logic [7:0]      MFR_ID   = 8'h01,
    parameter logic [DQ_W-1:0] DEV_ID   = 'h22C5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ident_mode,
    input  logic                byte_mode,
    input  logic [HI_W-1:0]     addr_hi,
    input  logic                addr_b6,
    input  logic [1:0]          addr_off,
    input  logic [NUM_SECT-1:0] sect_prot,
    output logic [DQ_W-1:0]     rdata
);
    logic [DQ_W-1:0]   val;
    logic [SECT_W-1:0] sidx;

    assign sidx = sector_of(addr_hi, TOP_BOOT);

    always_comb begin
        val = '0;
        if (ident_mode && !addr_b6) begin
            unique case (addr_off)
                2'd0:    val = DQ_W'(MFR_ID);
                2'd1:    val = DEV_ID;
                2'd2:    val = DQ_W'(sect_prot[sidx]);
                default: val = '0;
            endcase
        end
        if (byte_mode) val[DQ_W-1:8] = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) rdata <= '0;
        else     rdata <= val;
    end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import fcd_pkg::*;
#(
    parameter int              WA_W     = 19,
    parameter int              DQ_W     = 16,
    parameter bit              TOP_BOOT = 1'b1,
    parameter logic [7:0]      MFR_ID   = 8'h01,
    parameter logic [DQ_W-1:0] DEV_ID   = 'h22C5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_ce_n,
    input  logic                bus_we_n,
    input  logic                bus_oe_n,
    input  logic [WA_W-1:0]     bus_addr,
    input  logic                bus_addr_lsb,
    input  logic [DQ_W-1:0]     bus_dq,
    input  logic                byte_mode,
    input  logic                vdd_low,
    input  logic                pgm_busy,
    input  logic                serase_busy,
    input  logic [NUM_SECT-1:0] sect_prot,
    output logic                ident_mode,
    output logic [DQ_W-1:0]     ident_data,
    output logic                cmd_reset,
    output logic                cmd_ident,
    output logic                cmd_prog,
    output logic [WA_W-1:0]     prog_addr,
    output logic                prog_lsb,
    output logic [DQ_W-1:0]     prog_data,
    output logic                cmd_chip_erase,
    output logic                cmd_sect_erase,
    output logic [SECT_W-1:0]   erase_sector,
    output logic                cmd_suspend,
    output logic                cmd_resume
);
    logic            wr_end;
    logic [WA_W-1:0] lat_addr;
    logic            lat_lsb;
    cmd_pulse_t      pulse;

    fcd_bus_front #(.WA_W(WA_W)) u_front (
        .clk      (clk),
        .rst      (rst),
        .ce_n     (bus_ce_n),
        .we_n     (bus_we_n),
        .oe_n     (bus_oe_n),
        .addr     (bus_addr),
        .addr_lsb (bus_addr_lsb),
        .wr_end   (wr_end),
        .lat_addr (lat_addr),
        .lat_lsb  (lat_lsb)
    );

    fcd_seq_ctrl #(.WA_W(WA_W), .DQ_W(DQ_W), .TOP_BOOT(TOP_BOOT)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .wr_end       (wr_end),
        .lat_addr     (lat_addr),
        .lat_lsb      (lat_lsb),
        .dq           (bus_dq),
        .byte_mode    (byte_mode),
        .vdd_low      (vdd_low),
        .pgm_busy     (pgm_busy),
        .serase_busy  (serase_busy),
        .ident_mode   (ident_mode),
        .pulse        (pulse),
        .prog_addr    (prog_addr),
        .prog_lsb     (prog_lsb),
        .prog_data    (prog_data),
        .erase_sector (erase_sector)
    );

    fcd_ident_rom #(.DQ_W(DQ_W), .TOP_BOOT(TOP_BOOT), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) u_rom (
        .clk        (clk),
        .rst        (rst),
        .ident_mode (ident_mode),
        .byte_mode  (byte_mode),
        .addr_hi    (bus_addr[WA_W-1 -: HI_W]),
        .addr_b6    (bus_addr[6]),
        .addr_off   (bus_addr[1:0]),
        .sect_prot  (sect_prot),
        .rdata      (ident_data)
    );

    assign cmd_reset      = pulse.rst_rd;
    assign cmd_ident      = pulse.ident;
    assign cmd_prog       = pulse.prog;
    assign cmd_chip_erase = pulse.chip_ers;
    assign cmd_sect_erase = pulse.sect_ers;
    assign cmd_suspend    = pulse.hold;
    assign cmd_resume     = pulse.cont;

endmodule

// File: rtl/fcd_checker.sv
module fcd_checker #(
    parameter int DQ_W = 16
) (
    input logic            clk,
    input logic            rst,
    input logic            vdd_low,
    input logic            pgm_busy,
    input logic            serase_busy,
    input logic            ident_mode,
    input logic [DQ_W-1:0] ident_data,
    input logic            cmd_reset,
    input logic            cmd_ident,
    input logic            cmd_prog,
    input logic            cmd_chip_erase,
    input logic            cmd_sect_erase,
    input logic            cmd_suspend,
    input logic            cmd_resume
);
    logic [6:0] strobes;
    logic       any_strobe;

    assign strobes    = {cmd_reset, cmd_ident, cmd_prog, cmd_chip_erase,
                         cmd_sect_erase, cmd_suspend, cmd_resume};
    assign any_strobe = |strobes;

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(strobes)); // R12

    AST_STROBE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        any_strobe |=> !any_strobe); // R12

    AST_LOCKOUT_QUIET: assert property (@(posedge clk) disable iff (rst)
        vdd_low |=> !any_strobe); // R11

    AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (rst)
        pgm_busy |=> !any_strobe); // R11

    AST_HOLD_NEEDS_ERASE: assert property (@(posedge clk) disable iff (rst)
        (cmd_suspend || cmd_resume) |-> $past(serase_busy)); // R10

    AST_IDENT_ENTERS_MODE: assert property (@(posedge clk) disable iff (rst)
        cmd_ident |-> ident_mode); // R5

    AST_RESET_LEAVES_MODE: assert property (@(posedge clk) disable iff (rst)
        cmd_reset |-> !ident_mode); // R9

    AST_IDENT_DATA_IDLE: assert property (@(posedge clk) disable iff (rst)
        !$past(ident_mode) |-> (ident_data == '0)); // R5

endmodule

bind flash_cmd_decoder fcd_checker #(.DQ_W(DQ_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .vdd_low        (vdd_low),
    .pgm_busy       (pgm_busy),
    .serase_busy    (serase_busy),
    .ident_mode     (ident_mode),
    .ident_data     (ident_data),
    .cmd_reset      (cmd_reset),
    .cmd_ident      (cmd_ident),
    .cmd_prog       (cmd_prog),
    .cmd_chip_erase (cmd_chip_erase),
    .cmd_sect_erase (cmd_sect_erase),
    .cmd_suspend    (cmd_suspend),
    .cmd_resume     (cmd_resume)
);

// File: tb/flash_cmd_decoder_tb.sv
module flash_cmd_decoder_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WA_W = 19;
    localparam int DQ_W = 16;
    localparam logic [15:0] DEV = 16'h22C5;
    localparam logic [18:0] PROT = 19'b101_0110_0101_1001_1011;

    localparam int EV_RST = 1, EV_ID = 2, EV_PRG = 3, EV_CHIP = 4,
                   EV_SECT = 5, EV_SUSP = 6, EV_RES = 7;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [WA_W-1:0] addr = '0;
    logic lsb = 1'b0;
    logic [DQ_W-1:0] dq = '0;
    logic byte_mode = 1'b0, vdd_low = 1'b0, pgm_busy = 1'b0, serase_busy = 1'b0;
    logic ident_mode, prog_lsb, cmd_reset, cmd_ident, cmd_prog;
    logic cmd_chip_erase, cmd_sect_erase, cmd_suspend, cmd_resume;
    logic [DQ_W-1:0] ident_data, prog_data;
    logic [WA_W-1:0] prog_addr;
    logic [4:0] erase_sector;

    int checks = 0, errors = 0, cyc = 0;
    int ev_cnt = 0, ev_kind = 0, ev_cyc = 0, rise_cyc = 0, ev_sect = 0;
    logic [WA_W-1:0] ev_pa;
    logic ev_pl;
    logic [DQ_W-1:0] ev_pd;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    flash_cmd_decoder #(.WA_W(WA_W), .DQ_W(DQ_W), .TOP_BOOT(1'b1),
                        .MFR_ID(8'h01), .DEV_ID(DEV)) u_dut (
        .clk(clk), .rst(rst), .bus_ce_n(ce_n), .bus_we_n(we_n), .bus_oe_n(oe_n),
        .bus_addr(addr), .bus_addr_lsb(lsb), .bus_dq(dq), .byte_mode(byte_mode),
        .vdd_low(vdd_low), .pgm_busy(pgm_busy), .serase_busy(serase_busy),
        .sect_prot(PROT), .ident_mode(ident_mode), .ident_data(ident_data),
        .cmd_reset(cmd_reset), .cmd_ident(cmd_ident), .cmd_prog(cmd_prog),
        .prog_addr(prog_addr), .prog_lsb(prog_lsb), .prog_data(prog_data),
        .cmd_chip_erase(cmd_chip_erase), .cmd_sect_erase(cmd_sect_erase),
        .erase_sector(erase_sector), .cmd_suspend(cmd_suspend), .cmd_resume(cmd_resume));

    always @(negedge clk) begin
        int n;
        n = int'(cmd_reset) + int'(cmd_ident) + int'(cmd_prog) + int'(cmd_chip_erase)
          + int'(cmd_sect_erase) + int'(cmd_suspend) + int'(cmd_resume);
        if (n > 0) begin
            ev_cnt += n;
            ev_cyc = cyc;
            if (cmd_reset)      ev_kind = EV_RST;
            if (cmd_ident)      ev_kind = EV_ID;
            if (cmd_prog)       ev_kind = EV_PRG;
            if (cmd_chip_erase) ev_kind = EV_CHIP;
            if (cmd_sect_erase) ev_kind = EV_SECT;
            if (cmd_suspend)    ev_kind = EV_SUSP;
            if (cmd_resume)     ev_kind = EV_RES;
            ev_sect = int'(erase_sector);
            ev_pa = prog_addr; ev_pl = prog_lsb; ev_pd = prog_data;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clr(); ev_cnt = 0; ev_kind = 0; endtask

    task automatic expect_ev(input int kind, input string tag);
        chk(ev_cnt == 1 && ev_kind == kind, tag, ev_cnt * 16 + ev_kind, 16 + kind);
        clr();
    endtask

    task automatic expect_none(input string tag);
        chk(ev_cnt == 0, tag, ev_cnt, 0);
        clr();
    endtask

    task automatic wr_oe(input logic [WA_W-1:0] a, input logic l, input logic [DQ_W-1:0] d,
                         input logic oe);
        @(negedge clk);
        addr = a; lsb = l; dq = d; oe_n = oe; ce_n = 1'b0;
        @(negedge clk);
        we_n = 1'b0;
        repeat (4) @(negedge clk);
        we_n = 1'b1;
        rise_cyc = cyc;
        repeat (5) @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [WA_W-1:0] a, input logic l, input logic [DQ_W-1:0] d);
        wr_oe(a, l, d, 1'b1);
    endtask

    // Key pair; in byte mode key B carries lsb 1 (byte 555h), key A lsb 0 (byte AAAh)
    task automatic keys();
        wr(19'h00555, 1'b0, 16'h00AA);
        wr(19'h002AA, byte_mode, 16'h0055);
    endtask

    task automatic rd(input logic [WA_W-1:0] a, input logic [DQ_W-1:0] exp, input string tag);
        @(negedge clk);
        addr = a;
        repeat (2) @(negedge clk);
        chk(ident_data == exp, tag, ident_data, exp);
    endtask

    function automatic int ref_sector(input int a7);
        int wa;
        wa = a7 * 4096;
        if (wa < 'h78000)      return wa / 'h8000;
        else if (wa < 'h7C000) return 15;
        else if (wa < 'h7D000) return 16;
        else if (wa < 'h7E000) return 17;
        else                   return 18;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // R1 reset state
        chk(ident_mode == 1'b0, "R1 ident_mode", ident_mode, 0);
        chk(ident_data == '0, "R1 ident_data", ident_data, 0);
        expect_none("R1 no strobe");

        // R2 write with output enable low is not a write
        wr_oe(19'h00555, 1'b0, 16'h00AA, 1'b0);
        wr(19'h002AA, 1'b0, 16'h0055);
        wr(19'h00555, 1'b0, 16'h0090);
        expect_none("R2 oe low ignored");
        chk(ident_mode == 1'b0, "R2 mode", ident_mode, 0);

        // R3 word mode ident, upper bits and lsb ignored; R12 latency
        wr(19'h7F555, 1'b1, 16'hFFAA);
        wr(19'h3A2AA, 1'b1, 16'h1255);
        wr(19'h40555, 1'b0, 16'h0090);
        chk(ev_cyc - rise_cyc == 3, "R12 latency", ev_cyc - rise_cyc, 3);
        expect_ev(EV_ID, "R3 ident entry");
        chk(ident_mode == 1'b1, "R5 mode on", ident_mode, 1);

        // R5 identification reads
        rd(19'h00000, 16'h0001, "R5 maker");
        rd(19'h12301, DEV, "R5 device");
        rd(19'h00041, 16'h0000, "R5 a6 high");
        rd(19'h00003, 16'h0000, "R5 offset3");
        for (int s = 0; s < 128; s++) begin
            int ix;
            ix = ref_sector(s);
            rd(WA_W'(s * 4096 + 2), DQ_W'(PROT[ix]), "R13 R5 protect");
        end
        byte_mode = 1'b1;
        rd(19'h00001, DEV & 16'h00FF, "R5 byte device");
        byte_mode = 1'b0;

        // R8 stray write ends ident
        wr(19'h00000, 1'b0, 16'h0012);
        expect_none("R8 stray");
        chk(ident_mode == 1'b0, "R8 ident exit", ident_mode, 0);
        rd(19'h00000, 16'h0000, "R5 idle read");

        // R9 reset from ident and mid-sequence
        keys(); wr(19'h00555, 1'b0, 16'h0090); clr();
        wr(19'h1234F, 1'b1, 16'h00F0);
        expect_ev(EV_RST, "R9 reset");
        chk(ident_mode == 1'b0, "R9 mode off", ident_mode, 0);
        keys(); wr(19'h00000, 1'b0, 16'h00F0);
        expect_ev(EV_RST, "R9 reset mid");
        wr(19'h00555, 1'b0, 16'h0090);
        expect_none("R9 sequence dropped");

        // R6 program
        keys(); wr(19'h00555, 1'b0, 16'h00A0);
        wr(19'h12345, 1'b1, 16'hBEEF);
        chk(ev_pa == 19'h12345 && ev_pl == 1'b1, "R6 addr", ev_pa, 19'h12345);
        chk(ev_pd == 16'hBEEF, "R6 data", ev_pd, 16'hBEEF);
        expect_ev(EV_PRG, "R6 program");
        keys(); wr(19'h00555, 1'b0, 16'h00A0);
        wr(19'h00777, 1'b0, 16'h00F0);
        chk(ev_pd == 16'h00F0, "R6 F0 data", ev_pd, 16'h00F0);
        expect_ev(EV_PRG, "R6 F0 programs");

        // R7 chip erase and sector sweep
        keys(); wr(19'h00555, 1'b0, 16'h0080); keys(); wr(19'h00555, 1'b0, 16'h0010);
        expect_ev(EV_CHIP, "R7 chip erase");
        for (int s = 0; s < 128; s++) begin
            keys(); wr(19'h00555, 1'b0, 16'h0080); keys();
            wr(WA_W'(s * 4096 + 'h123), 1'b0, 16'h0030);
            chk(ev_sect == ref_sector(s), "R13 sector", ev_sect, ref_sector(s));
            expect_ev(EV_SECT, "R7 sector erase");
        end

        // R8 aborts
        wr(19'h00555, 1'b0, 16'h00AA); wr(19'h002AA, 1'b0, 16'h0054);
        wr(19'h00555, 1'b0, 16'h0090);
        expect_none("R8 bad data");
        wr(19'h00555, 1'b0, 16'h00AA); wr(19'h002AB, 1'b0, 16'h0055);
        wr(19'h00555, 1'b0, 16'h0090);
        expect_none("R8 bad addr");
        wr(19'h002AA, 1'b0, 16'h0055); wr(19'h00555, 1'b0, 16'h00AA);
        wr(19'h00555, 1'b0, 16'h0090);
        expect_none("R8 bad order");
        keys(); wr(19'h00555, 1'b0, 16'h0077);
        expect_none("R8 bad command");
        keys(); wr(19'h00555, 1'b0, 16'h0080); keys(); wr(19'h00554, 1'b0, 16'h0010);
        expect_none("R8 chip bad addr");
        chk(ident_mode == 1'b0, "R8 read mode", ident_mode, 0);

        // R4 byte mode
        byte_mode = 1'b1;
        keys(); wr(19'h00555, 1'b0, 16'h0090);
        expect_ev(EV_ID, "R4 byte ident");
        wr(19'h00000, 1'b0, 16'h00F0); clr();
        wr(19'h00555, 1'b0, 16'h00AA); wr(19'h002AA, 1'b0, 16'h0055);
        wr(19'h00555, 1'b0, 16'h0090);
        expect_none("R4 key B lsb 0");
        keys(); wr(19'h00555, 1'b1, 16'h0090);
        expect_none("R4 command lsb 1");
        keys(); wr(19'h00555, 1'b0, 16'h00A0); wr(19'h00100, 1'b1, 16'h005A);
        chk(ev_pa == 19'h00100 && ev_pl == 1'b1 && ev_pd == 16'h005A, "R4 byte program",
            ev_pd, 16'h005A);
        expect_ev(EV_PRG, "R4 byte program strobe");
        byte_mode = 1'b0;

        // R10 suspend / resume
        wr(19'h00321, 1'b0, 16'h00B0);
        wr(19'h00321, 1'b0, 16'h0030);
        expect_none("R10 idle erase");
        serase_busy = 1'b1;
        wr(19'h54321, 1'b1, 16'h00B0);
        expect_ev(EV_SUSP, "R10 suspend");
        wr(19'h00007, 1'b0, 16'h0030);
        expect_ev(EV_RES, "R10 resume");
        serase_busy = 1'b0;

        // R11 lockout and program busy
        vdd_low = 1'b1;
        keys(); wr(19'h00555, 1'b0, 16'h0090); wr(19'h0, 1'b0, 16'h00F0);
        vdd_low = 1'b0;
        expect_none("R11 lockout");
        wr(19'h00555, 1'b0, 16'h00A0); wr(19'h00010, 1'b0, 16'h0011);
        expect_none("R11 lockout no advance");
        pgm_busy = 1'b1;
        keys();
        wr(19'h0, 1'b0, 16'h00F0);
        pgm_busy = 1'b0;
        expect_none("R11 busy");
        wr(19'h00555, 1'b0, 16'h00A0); wr(19'h00010, 1'b0, 16'h0011);
        expect_none("R11 busy no advance");
        chk(ident_mode == 1'b0, "R11 mode", ident_mode, 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule